// File: doc/BRIEF.md
# Class-Partitioned Integer ALU

This block is a purely combinational integer ALU for a datapath of `W` bits (32 by default). It takes two operands and a 4-bit operation code, and it returns a single `W`-bit result. It implements thirteen operations in four families: bitwise logic, add/subtract, set-less-than, and shifts.

Decoding happens in two levels. Four family units each form their own result at the same moment. The upper two code bits then steer a 4-to-1 bus multiplexer that chooses one of the four family results. The lower two code bits choose the operation inside each family.

The set-less-than unit never reads full operands. It takes only the two operand sign bits, together with the difference and carry-out that the add/subtract unit produces. The add/subtract unit performs a subtraction whenever the comparison family is selected.

Top module: `cls_alu`

## Requirements
- R1: Codes 0000, 0001, 0010 and 0011 give bitwise AND, OR, NOR and XOR of `opnd_a` and `opnd_b`.
- R2: Codes 0100 and 0101 give `opnd_a + opnd_b` modulo 2^W. Codes 0110 and 0111 give `opnd_a - opnd_b` modulo 2^W. The signed and unsigned variants give identical results. An internal signed-overflow indication is raised for 0100/0110 exactly when the two's-complement result has the wrong sign.
- R3: Code 1000 returns 1 in bit 0 when `opnd_a` is less than `opnd_b` as two's-complement numbers, and 0 otherwise.
- R4: Code 1001 returns 1 in bit 0 when `opnd_a` is less than `opnd_b` as unsigned numbers, and 0 otherwise.
- R5: Codes 1100, 1101 and 1110 shift `opnd_a` left logically, right logically, and right arithmetically. For the arithmetic right shift, bit W-1 of `opnd_a` fills the vacated bits.
- R6: The unused codes 1010, 1011 and 1111 give a result of all zeros.
- R7: For every comparison-family code (10xx), bits W-1 down to 1 of `result` are zero.
- R8: The signed and unsigned compares return 0 for equal operands. They handle sign-differing operands correctly, including the most negative value against any positive value, where the subtraction overflows.
- R9: The shift amount is the low log2(W) bits of `opnd_b`. Higher bits of `opnd_b` have no effect on shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand; also the value that is shifted |
| opnd_b | input | W | Second operand; its low log2(W) bits give the shift amount |
| op_code | input | 4 | Bits [3:2] select the family (00 logic, 01 add/sub, 10 compare, 11 shift); bits [1:0] select the operation within it |
| result | output | W | Selected result |

## Verification
The add/subtract and compare functions act together in the same evaluation. When the compare family is selected, the subtractor must run on the same operands, and its sign and carry must be combined with the raw sign bits. A mistake in the steering of the subtract control, or in the borrow polarity, therefore shows up only as a wrong compare answer. This interaction is provoked by a full sweep of both 8-bit operands under every code on a narrow instance. That sweep includes the overflowing sign-differing pairs. Each answer is judged against a signed and unsigned comparison done in integer arithmetic. Directed 32-bit corner vectors repeat the overflow cases at full width.

// File: rtl/cls_alu_pkg.sv
package cls_alu_pkg;

    typedef enum logic [1:0] {
        FAM_LOGIC = 2'b00,
        FAM_ARITH = 2'b01,
        FAM_CMP   = 2'b10,
        FAM_SHIFT = 2'b11
    } family_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_NOR = 2'b10,
        LG_XOR = 2'b11
    } logic_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_ARITH = 2'b10,
        SH_NONE  = 2'b11
    } shift_sel_e;

    typedef enum logic [1:0] {
        CP_SIGNED   = 2'b00,
        CP_UNSIGNED = 2'b01,
        CP_RSV2     = 2'b10,
        CP_RSV3     = 2'b11
    } cmp_sel_e;

endpackage

// File: rtl/cls_alu_logic.sv
module cls_alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    import cls_alu_pkg::*;

    logic [W-1:0] res_d;

    always_comb begin
        res_d = '0;
        unique case (logic_sel_e'(sel_i))
            LG_AND: res_d = a_i & b_i;
            LG_OR:  res_d = a_i | b_i;
            LG_NOR: res_d = ~(a_i | b_i);
            LG_XOR: res_d = a_i ^ b_i;
            default: res_d = '0;
        endcase
    end

    assign res_o = res_d;
endmodule

// File: rtl/cls_alu_arith.sv
module cls_alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         signed_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    typedef struct packed {
        logic [W:0] wide;
        logic       ovf;
    } arith_t;

    arith_t       st_d;
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff      = sub_i ? ~b_i : b_i;
        st_d.wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        // wrong-sign detection on the two's-complement sum
        st_d.ovf   = signed_i
                   & (a_i[W-1] == b_eff[W-1])
                   & (st_d.wide[W-1] != a_i[W-1]);
    end

    assign sum_o   = st_d.wide[W-1:0];
    assign carry_o = st_d.wide[W];
    assign ovf_o   = st_d.ovf;
endmodule

// File: rtl/cls_alu_cmp.sv
module cls_alu_cmp #(
    parameter int W = 32
) (
    input  logic         sign_a_i,
    input  logic         sign_b_i,
    input  logic         diff_msb_i,
    input  logic         carry_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    import cls_alu_pkg::*;

    logic lt_d;

    always_comb begin
        lt_d = 1'b0;
        unique case (cmp_sel_e'(sel_i))
            CP_SIGNED:   lt_d = (sign_a_i != sign_b_i) ? sign_a_i : diff_msb_i;
            CP_UNSIGNED: lt_d = ~carry_i;
            default:     lt_d = 1'b0;
        endcase
    end

    assign res_o = {{(W-1){1'b0}}, lt_d};
endmodule

// File: rtl/cls_alu_shift.sv
module cls_alu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    import cls_alu_pkg::*;

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt;
    logic [W-1:0]   res_d;

    always_comb begin
        amt   = b_i[SHW-1:0];
        res_d = '0;
        unique case (shift_sel_e'(sel_i))
            SH_LEFT:  res_d = a_i << amt;
            SH_RIGHT: res_d = a_i >> amt;
            SH_ARITH: res_d = W'($signed(a_i) >>> amt);
            default:  res_d = '0;
        endcase
    end

    assign res_o = res_d;
endmodule

// File: rtl/cls_alu_mux4.sv
module cls_alu_mux4 #(
    parameter int W = 32
) (
    input  logic [3:0][W-1:0] in_i,
    input  logic [1:0]        sel_i,
    output logic [W-1:0]      out_o
);
    assign out_o = in_i[sel_i];
endmodule

// File: rtl/cls_alu.sv
module cls_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   op_code,
    output logic [W-1:0] result
);
    import cls_alu_pkg::*;

    logic [1:0]        fam;
    logic [1:0]        sub_sel;
    logic              sub_en;
    logic              signed_en;
    logic [W-1:0]      diff;
    logic              carry;
    logic              ovf;
    logic [3:0][W-1:0] fam_res;

    assign fam       = op_code[3:2];
    assign sub_sel   = op_code[1:0];
    // the compare family always needs A-B from the adder
    assign sub_en    = sub_sel[1] | (family_e'(fam) == FAM_CMP);
    assign signed_en = (family_e'(fam) == FAM_ARITH) & ~sub_sel[0];

    cls_alu_logic #(.W(W)) u_logic (
        .a_i(opnd_a), .b_i(opnd_b), .sel_i(sub_sel), .res_o(fam_res[FAM_LOGIC])
    );

    cls_alu_arith #(.W(W)) u_arith (
        .a_i(opnd_a), .b_i(opnd_b), .sub_i(sub_en), .signed_i(signed_en),
        .sum_o(diff), .carry_o(carry), .ovf_o(ovf)
    );
    assign fam_res[FAM_ARITH] = diff;

    cls_alu_cmp #(.W(W)) u_cmp (
        .sign_a_i(opnd_a[W-1]), .sign_b_i(opnd_b[W-1]),
        .diff_msb_i(diff[W-1]), .carry_i(carry),
        .sel_i(sub_sel), .res_o(fam_res[FAM_CMP])
    );

    cls_alu_shift #(.W(W)) u_shift (
        .a_i(opnd_a), .b_i(opnd_b), .sel_i(sub_sel), .res_o(fam_res[FAM_SHIFT])
    );

    cls_alu_mux4 #(.W(W)) u_mux (
        .in_i(fam_res), .sel_i(fam), .out_o(result)
    );
endmodule

// File: rtl/cls_alu_chk.sv
module cls_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   op_code,
    input logic [W-1:0] result,
    input logic         ovf
);
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_code, result, ovf})) begin
            AST_CMP_UPPER_ZERO: assert (op_code[3:2] != 2'b10 || result[W-1:1] == '0); // R7
            AST_UNUSED_ZERO: assert (!(op_code == 4'b1010 || op_code == 4'b1011 || op_code == 4'b1111) || result == '0); // R6
            AST_ADD_INVERSE: assert (op_code[3:1] != 3'b010 || W'(result - opnd_b) == opnd_a); // R2
            AST_SUB_INVERSE: assert (op_code[3:1] != 3'b011 || W'(result + opnd_b) == opnd_a); // R2
            AST_SIGNED_OVF: assert (!(op_code == 4'b0100) || ovf == ((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1]))); // R2
            AST_SLT_SIGNED: assert (op_code != 4'b1000 || result[0] == ($signed(opnd_a) < $signed(opnd_b))); // R3
            AST_SLT_UNSIGNED: assert (op_code != 4'b1001 || result[0] == (opnd_a < opnd_b)); // R4
            AST_SRA_SIGN_FILL: assert (op_code != 4'b1110 || result[W-1] == opnd_a[W-1]); // R5
            AST_XOR_NOR_PAIR: assert (op_code != 4'b0011 || (result | (opnd_a & opnd_b) | ~(opnd_a | opnd_b)) == '1); // R1
        end
    end
endmodule

bind cls_alu cls_alu_chk #(.W(W)) chk_i (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code), .result(result), .ovf(ovf)
);

// File: tb/cls_alu_tb_top.sv
module cls_alu_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n;
    logic [7:0]  a8, b8, r8;
    logic [31:0] a32, b32, r32;
    logic [3:0]  op8, op32;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cls_alu #(.W(8))  dut_n (.opnd_a(a8),  .opnd_b(b8),  .op_code(op8),  .result(r8));
    cls_alu #(.W(32)) dut_i (.opnd_a(a32), .opnd_b(b32), .op_code(op32), .result(r32));

    function automatic longint sx(longint v, int n);
        if (v[n-1]) return v - (longint'(1) << n);
        return v;
    endfunction

    function automatic logic [31:0] model(int n, logic [3:0] op, logic [31:0] a, logic [31:0] b);
        longint m  = (longint'(1) << n) - 1;
        longint ua = longint'(a) & m;
        longint ub = longint'(b) & m;
        longint sa = sx(ua, n);
        longint sb = sx(ub, n);
        int     sh = int'(ub & longint'(n - 1));
        longint r;
        case (op)
            4'h0: r = ua & ub;
            4'h1: r = ua | ub;
            4'h2: r = ~(ua | ub);
            4'h3: r = ua ^ ub;
            4'h4, 4'h5: r = ua + ub;
            4'h6, 4'h7: r = ua - ub;
            4'h8: r = (sa < sb) ? 1 : 0;
            4'h9: r = (ua < ub) ? 1 : 0;
            4'hC: r = ua << sh;
            4'hD: r = ua >> sh;
            4'hE: r = sa >>> sh;
            default: r = 0;
        endcase
        return 32'(r & m);
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'h0, 4'h1, 4'h2, 4'h3: return "R1";
            4'h4, 4'h5, 4'h6, 4'h7: return "R2";
            4'h8: return "R3";
            4'h9: return "R4";
            4'hC, 4'hD, 4'hE: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic v32(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b);
        op32 = op; a32 = a; b32 = b;
        #2;
        check(req, r32, model(32, op, a, b));
    endtask

    initial begin
        rst_n = 1'b0;
        a8 = '0; b8 = '0; op8 = '0;
        a32 = '0; b32 = '0; op32 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 idle", r32, 32'h0);

        // narrow instance: every code, every operand pair (R7 and R9 covered too)
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    op8 = 4'(op); a8 = 8'(a); b8 = 8'(b);
                    #1;
                    check(req_of(4'(op)), {24'h0, r8}, model(8, 4'(op), 32'(a), 32'(b)));
                end
            end
        end

        // full width corners
        v32("R1", 4'h2, 32'hF0F0_0000, 32'h0F00_00FF);
        v32("R2", 4'h4, 32'hFFFF_FFFF, 32'h0000_0001);
        v32("R2", 4'h5, 32'h7FFF_FFFF, 32'h0000_0001);
        v32("R2", 4'h6, 32'h0000_0000, 32'h0000_0001);
        v32("R2", 4'h7, 32'h8000_0000, 32'h0000_0001);
        v32("R3", 4'h8, 32'hFFFF_FFFF, 32'h0000_0000);
        v32("R8", 4'h8, 32'h8000_0000, 32'h7FFF_FFFF);
        v32("R8", 4'h8, 32'h7FFF_FFFF, 32'h8000_0000);
        v32("R8", 4'h8, 32'h1234_5678, 32'h1234_5678);
        v32("R8", 4'h9, 32'h1234_5678, 32'h1234_5678);
        v32("R4", 4'h9, 32'h0000_0001, 32'hFFFF_FFFF);
        v32("R4", 4'h9, 32'h8000_0000, 32'h7FFF_FFFF);
        v32("R5", 4'hE, 32'h8000_0000, 32'h0000_001F);
        v32("R5", 4'hC, 32'h0000_0001, 32'h0000_001F);
        v32("R9", 4'hD, 32'hF000_0000, 32'hFFFF_FFE3);
        v32("R9", 4'hC, 32'h0000_00FF, 32'h0000_0120);
        v32("R6", 4'hA, 32'hFFFF_FFFF, 32'h0000_0001);
        v32("R6", 4'hB, 32'h0000_0000, 32'hFFFF_FFFF);
        v32("R6", 4'hF, 32'hDEAD_BEEF, 32'h0000_0004);
        v32("R7", 4'h8, 32'h8000_0000, 32'h0000_0001);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule